// File: doc/BRIEF.md
# Load-Adaptive Event Queue Drain Arbiter

This block empties eight first-word-fall-through event queues into one shared output queue, moving no more than one event per clock. Each input queue reports whether it is empty, how many words it holds and the word at its head. The arbiter answers with a read strobe to at most one queue. The output queue reports when it is full, and the arbiter drives a 17-bit event and a write strobe to it. An event carries a valid flag in bit 16 and a target neuron address in bits 15:0. The arbiter passes the event through without changing it.

Under light load the arbiter offers turns in a fixed cyclic order that advances every clock. When the summed word count of all queues is larger than a threshold input, the arbiter gives the turn to the fullest queue instead, so a heavy backlog drains before it overflows. The decision is combinational. The read strobe, the forwarded data and the write strobe all appear in the same cycle as the flags that caused them. Only the rotation pointer is held in a register.

Top module: `qdrain_arbiter`

## Requirements
- R1: After a cycle with `rst` high at a rising edge, the rotation pointer is 0. In the first cycle after reset, in rotating mode, only queue 0 can be granted.
- R2: A transfer occurs only if the chosen queue is not empty and `out_full` is low. In that cycle exactly that queue's `q_rd` bit is high and `out_wr` is high. Every queued event leaves exactly once and in its queue's order.
- R3: In rotating mode the chosen queue is the pointer. The pointer advances by one on every clock without reset, whether or not a transfer happens, and it wraps from 7 to 0.
- R4: In priority mode the chosen queue is the one with the largest `q_count` field. On a tie the lowest-numbered queue wins.
- R5: The mode is priority when the sum of the eight counts is strictly greater than `thresh`. When the sum is equal to or below it, the mode is rotating. The threshold is read anew every cycle.
- R6: At most one `q_rd` bit is high in any cycle. `out_wr` is high only in a cycle in which a `q_rd` bit is high.
- R7: While `out_full` is high, no `q_rd` bit and no `out_wr` is asserted, and the pointer keeps advancing. A queue whose turn passes during the stall waits for its next turn.
- R8: In any cycle without a transfer, `out_data` is all zeros.
- R9: During a transfer, `out_data` equals the 17-bit head word of the granted queue, bit for bit. Bit 16 is the valid flag and bits 15:0 are the address.
- R10: The count sum is formed at 13 bits and cannot overflow. With all eight counts at 1023 the sum is 8184. That sum selects priority mode against a threshold of 8183 and rotating mode against 8184.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thresh | input | 13 | Backlog threshold for priority mode |
| q_empty | input | 8 | Empty flag per input queue, bit i for queue i |
| q_count | input | 80 | Word count per queue, queue i in bits 10*i+9 : 10*i |
| q_data | input | 136 | Head word per queue, queue i in bits 17*i+16 : 17*i |
| q_rd | output | 8 | Read strobe per input queue |
| out_full | input | 1 | Output queue full |
| out_data | output | 17 | Event written to the output queue |
| out_wr | output | 1 | Write strobe to the output queue |

## Verification
The mode change and the output stall can fall in the same cycle. In that cycle the selection switches between the pointer and the fullest queue while backpressure blocks the transfer and the pointer still advances. The bench provokes this by sweeping the threshold across the live backlog while it asserts the full flag at random and fills the queues at varied rates. It judges every cycle against its own pointer, computed from cycles since reset, and its own arithmetic mode decision. It also checks the tagged sequence number of each event, so that a skipped or repeated event shows up at once.

// File: rtl/qdrain_pkg.sv
package qdrain_pkg;
  localparam int QD_NQ = 8;
  localparam int QD_DW = 17;
  localparam int QD_CW = 10;

  typedef enum logic {
    MODE_ROTATE  = 1'b0,
    MODE_FULLEST = 1'b1
  } qd_mode_e;
endpackage

// File: rtl/qdrain_rotor.sv
module qdrain_rotor #(
  parameter int NQ = 8,
  parameter int PW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(NQ - 1);

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (ptr == LAST)
      ptr <= '0;
    else
      ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/qdrain_load_sum.sv
module qdrain_load_sum #(
  parameter int NQ = 8,
  parameter int CW = 10,
  parameter int SW = CW + $clog2(NQ)
) (
  input  logic [NQ*CW-1:0] counts,
  output logic [SW-1:0]    total
);
  always_comb begin
    total = '0;
    for (int i = 0; i < NQ; i++)
      total = total + {{(SW-CW){1'b0}}, counts[i*CW +: CW]};
  end
endmodule

// File: rtl/qdrain_fullest.sv
module qdrain_fullest #(
  parameter int NQ = 8,
  parameter int CW = 10,
  parameter int PW = $clog2(NQ)
) (
  input  logic [NQ*CW-1:0] counts,
  output logic [PW-1:0]    idx
);
  logic [CW-1:0] best;

  always_comb begin
    best = counts[CW-1:0];
    idx  = '0;
    for (int i = 1; i < NQ; i++) begin
      if (counts[i*CW +: CW] > best) begin
        best = counts[i*CW +: CW];
        idx  = PW'(i);
      end
    end
  end
endmodule

// File: rtl/qdrain_arbiter.sv
module qdrain_arbiter
  import qdrain_pkg::*;
#(
  parameter int NQ = QD_NQ,
  parameter int DW = QD_DW,
  parameter int CW = QD_CW,
  parameter int SW = CW + $clog2(NQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SW-1:0]    thresh,
  input  logic [NQ-1:0]    q_empty,
  input  logic [NQ*CW-1:0] q_count,
  input  logic [NQ*DW-1:0] q_data,
  output logic [NQ-1:0]    q_rd,
  input  logic             out_full,
  output logic [DW-1:0]    out_data,
  output logic             out_wr
);
  localparam int PW = $clog2(NQ);

  logic [PW-1:0] rot_ptr;
  logic [PW-1:0] max_idx;
  logic [PW-1:0] sel;
  logic [SW-1:0] backlog;
  qd_mode_e      mode;
  logic          go;

  qdrain_rotor #(.NQ(NQ), .PW(PW)) u_rotor (
    .clk (clk),
    .rst (rst),
    .ptr (rot_ptr)
  );

  qdrain_load_sum #(.NQ(NQ), .CW(CW), .SW(SW)) u_sum (
    .counts (q_count),
    .total  (backlog)
  );

  qdrain_fullest #(.NQ(NQ), .CW(CW), .PW(PW)) u_fullest (
    .counts (q_count),
    .idx    (max_idx)
  );

  assign mode = (backlog > thresh) ? MODE_FULLEST : MODE_ROTATE;
  assign sel  = (mode == MODE_FULLEST) ? max_idx : rot_ptr;
  assign go   = !q_empty[sel] && !out_full;

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_rd
      assign q_rd[g] = go && (sel == PW'(g));
    end
  endgenerate

  assign out_wr   = go;
  assign out_data = go ? q_data[int'(sel)*DW +: DW] : '0;
endmodule

// File: rtl/qdrain_arbiter_chk.sv
module qdrain_arbiter_chk #(
  parameter int NQ = 8,
  parameter int DW = 17,
  parameter int PW = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [NQ-1:0]    q_empty,
  input logic [NQ*DW-1:0] q_data,
  input logic [NQ-1:0]    q_rd,
  input logic             out_full,
  input logic [DW-1:0]    out_data,
  input logic             out_wr,
  input logic [PW-1:0]    ptr
);
  logic [DW-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NQ; i++)
      if (q_rd[i]) picked = picked | q_data[i*DW +: DW];
  end

  a_r6_onehot_rd: assert property (@(posedge clk) disable iff (rst)
    $onehot0(q_rd));

  a_r6_wr_needs_rd: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> (q_rd != '0));

  a_r7_full_blocks: assert property (@(posedge clk) disable iff (rst)
    out_full |-> (q_rd == '0) && !out_wr);

  a_r2_no_empty_read: assert property (@(posedge clk) disable iff (rst)
    (q_rd & q_empty) == '0);

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_wr |-> (out_data == '0));

  a_r9_forward: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> (out_data == picked));

  a_r1_ptr_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ptr == '0));

  a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (ptr == (($past(ptr) == PW'(NQ - 1)) ? '0 : $past(ptr) + 1'b1)));
endmodule

bind qdrain_arbiter qdrain_arbiter_chk #(.NQ(NQ), .DW(DW), .PW(PW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .q_empty  (q_empty),
  .q_data   (q_data),
  .q_rd     (q_rd),
  .out_full (out_full),
  .out_data (out_data),
  .out_wr   (out_wr),
  .ptr      (rot_ptr)
);

// File: tb/test_qdrain_arbiter.sv
module test_qdrain_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 8;
  localparam int DW = 17;
  localparam int CW = 10;
  localparam int SW = 13;
  localparam int CAP = 31;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [SW-1:0]    thresh = '1;
  logic [NQ-1:0]    q_empty = '1;
  logic [NQ*CW-1:0] q_count = '0;
  logic [NQ*DW-1:0] q_data = '0;
  logic [NQ-1:0]    q_rd;
  logic             out_full = 1'b0;
  logic [DW-1:0]    out_data;
  logic             out_wr;

  int n_cmp = 0;
  int n_bad = 0;
  int wr_seq [NQ];
  int rd_seq [NQ];
  int exp_ptr = 0;
  int fill_pct = 0;
  int full_pct = 0;
  bit force_max = 0;
  bit first_cycle = 0;

  qdrain_arbiter i_qdrain_arbiter (
    .clk(clk), .rst(rst), .thresh(thresh), .q_empty(q_empty),
    .q_count(q_count), .q_data(q_data), .q_rd(q_rd),
    .out_full(out_full), .out_data(out_data), .out_wr(out_wr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) exp_ptr <= 0;
    else     exp_ptr <= (exp_ptr + 1) % NQ;
  end

  function automatic logic [DW-1:0] ev(int q, int s);
    return {s[0] ^ q[0], q[2:0], s[12:0]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    int cnt [NQ];
    int sum, sel, best;
    bit prio, go;
    logic [NQ-1:0] e_rd;
    logic [DW-1:0] e_dat;
    string tag;
    @(negedge clk);
    for (int i = 0; i < NQ; i++) begin
      int occ = wr_seq[i] - rd_seq[i];
      q_empty[i] = (occ == 0);
      cnt[i] = force_max ? 1023 : occ;
      q_count[i*CW +: CW] = CW'(cnt[i]);
      q_data[i*DW +: DW] = (occ == 0) ? 17'h15A5A : ev(i, rd_seq[i]);
    end
    out_full = ($urandom_range(99) < full_pct);
    #1;
    sum = 0;
    for (int i = 0; i < NQ; i++) sum += cnt[i];
    prio = (sum > int'(thresh));
    best = -1; sel = 0;
    for (int i = NQ-1; i >= 0; i--)
      if (cnt[i] >= best) begin best = cnt[i]; sel = i; end
    if (!prio) sel = exp_ptr;
    go = !q_empty[sel] && !out_full;
    e_rd = '0;
    if (go) e_rd[sel] = 1'b1;
    e_dat = go ? ev(sel, rd_seq[sel]) : '0;
    if (first_cycle)    tag = "R1";
    else if (force_max) tag = "R10";
    else if (out_full)  tag = "R7";
    else if (prio)      tag = "R4";
    else                tag = "R3";
    chk(q_rd == e_rd, {tag, " R5 grant"}, int'(q_rd), int'(e_rd));
    chk(out_wr == go, "R2 write strobe", int'(out_wr), int'(go));
    chk(out_data == e_dat, go ? "R9 data" : "R8 idle data", int'(out_data), int'(e_dat));
    chk($countones(q_rd) <= 1, "R6 one-hot", int'(q_rd), 0);
    first_cycle = 0;
    if (go) rd_seq[sel]++;
    for (int i = 0; i < NQ; i++)
      if ((wr_seq[i] - rd_seq[i]) < CAP && $urandom_range(99) < fill_pct)
        wr_seq[i]++;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NQ; i++) begin wr_seq[i] = 0; rd_seq[i] = 0; end
    rst = 1'b1;
    thresh = '1;
    repeat (3) @(negedge clk);
    #1;
    chk(q_rd == '0 && !out_wr, "R1 reset idle", int'(q_rd), 0);
    chk(out_data == '0, "R8 reset data", int'(out_data), 0);
    for (int i = 0; i < NQ; i++) wr_seq[i] = 3;
    @(negedge clk);
    rst = 1'b0;
    first_cycle = 1;
    fill_pct = 0; full_pct = 0;
    repeat (24) step();

    // rotating mode under varied fill and stall rates
    thresh = '1;
    foreach (wr_seq[i]) ;
    for (int f = 0; f < 3; f++)
      for (int s = 0; s < 3; s++) begin
        fill_pct = 10 + 40 * f;
        full_pct = 35 * s;
        repeat (300) step();
      end

    // priority mode always on when any backlog exists
    thresh = '0;
    for (int f = 0; f < 3; f++) begin
      fill_pct = 20 + 35 * f;
      full_pct = 25;
      repeat (300) step();
    end

    // threshold sweep near the live backlog, with stalls
    for (int t = 0; t < 120; t++) begin
      thresh = SW'(t);
      fill_pct = 60;
      full_pct = 30;
      repeat (25) step();
    end

    // equal counts: ties go to the lowest queue
    fill_pct = 0; full_pct = 0; thresh = '0;
    for (int i = 0; i < NQ; i++) wr_seq[i] = rd_seq[i] + 5;
    repeat (40) step();

    // sum at its maximum width, both sides of the boundary
    for (int i = 0; i < NQ; i++) wr_seq[i] = rd_seq[i] + 4;
    force_max = 1;
    thresh = 13'd8183;
    repeat (12) step();
    thresh = 13'd8184;
    repeat (12) step();
    force_max = 0;

    // drain everything, then check each event left exactly once
    thresh = '1; fill_pct = 0; full_pct = 0;
    repeat (400) step();
    for (int i = 0; i < NQ; i++)
      chk(rd_seq[i] == wr_seq[i], "R2 drained once", rd_seq[i], wr_seq[i]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule